// File: doc/BRIEF.md
# Sample-Stream DC Offset Remover

This block takes a stream of 14-bit two's-complement converter samples, one per clock, and removes their DC component. A first-order feedback loop integrates the block's own corrected output. A scaled copy of that integral is the offset estimate, and the block subtracts it from every incoming sample. When the loop settles, the mean of the output is near zero. The loop time constant is a power of two in sample-clock cycles, chosen by a 3-bit code whose mapping does not follow the code order.

Three static configuration inputs control the loop. An enable bit switches the correction on. A freeze bit holds the estimate at its last value while the block keeps subtracting it. A 3-bit select chooses the time constant. The estimate is bounded to a small fraction of full scale, so the loop can only remove a small DC error. A parameter `TC_TRIM` shortens every time constant by the same power of two so that short runs can reach steady state.

Top module: `dc_trim_loop`

## Requirements
- R1: After reset, `out_valid` is 0 and `out_data` is 0. Each output sample appears one clock after its input, and `out_valid` follows `in_valid` with the same one-clock delay.
- R2: While `enable` is 0, `out_data` equals `in_data` unchanged and the accumulator is cleared to 0. After re-enabling, the first corrected sample therefore equals its input.
- R3: While `enable` is 1, `out_data` = in − est. The result saturates to the range −8192..8191 and never wraps.
- R4: On each valid sample with `enable`=1 and `freeze`=0, the corrected output is added to the accumulator. The sum is clamped to ±(LIMIT·2^k). The estimate is floor(acc / 2^k), clamped to ±LIMIT. LIMIT defaults to 128, which is 1/64 of full scale.
- R5: The shift is k = T − TC_TRIM, with T decoded from `tc_sel` as follows: 3'b011→24, 3'b010→25, 3'b001→26, 3'b000, 3'b110 and 3'b111→27, 3'b100→28, 3'b101→29.
- R6: While `freeze`=1 and `enable`=1, the accumulator holds its value and the held estimate is still subtracted. A constant input then gives a constant output.
- R7: A change of `tc_sel` applies to the next sample. The accumulator is not reset.
- R8: With a constant offset inside ±LIMIT plus a zero-mean tone, the mean of the corrected output converges to within ±3 codes of zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Turns the correction loop on |
| freeze | input | 1 | Holds the offset estimate |
| tc_sel | input | 3 | Time-constant code |
| in_valid | input | 1 | Input sample strobe |
| in_data | input | 14 | Input sample, two's complement |
| out_valid | output | 1 | Output sample strobe |
| out_data | output | 14 | Corrected sample, two's complement |

## Verification
On every cycle, the assertions check the valid latency, the bypass path while disabled, the clearing of the accumulator while disabled, the accumulator hold under freeze, and the bound on the estimate. Only the bench's scenarios can show the rest. These are the exact sample-by-sample arithmetic for every time-constant code, the convergence of the residual mean, saturation at both rails, clamping of an offset larger than the limit, and a code change that keeps the accumulator.

// File: rtl/dc_trim_loop.sv
module dc_trim_loop #(
  parameter int DW      = 14,
  parameter int LIMIT   = 128,
  parameter int TC_TRIM = 0,
  parameter int ACCW    = DW + 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 enable,
  input  logic                 freeze,
  input  logic [2:0]           tc_sel,
  input  logic                 in_valid,
  input  logic signed [DW-1:0] in_data,
  output logic                 out_valid,
  output logic signed [DW-1:0] out_data
);

  localparam logic signed [DW:0] SMAX = (DW+1)'((1 <<< (DW-1)) - 1);
  localparam logic signed [DW:0] SMIN = -(DW+1)'(1 <<< (DW-1));

  logic [5:0]              base, sh;
  logic signed [ACCW-1:0]  acc, acc_sum, acc_nxt, lim_w, lim_acc, est_raw, est_w;
  logic signed [DW-1:0]    est, y;
  logic signed [DW:0]      diff;

  always_comb begin
    case (tc_sel)
      3'b001:  base = 6'd26;
      3'b010:  base = 6'd25;
      3'b011:  base = 6'd24;
      3'b100:  base = 6'd28;
      3'b101:  base = 6'd29;
      default: base = 6'd27;
    endcase
  end
  assign sh = base - 6'(TC_TRIM);

  assign lim_w   = ACCW'(LIMIT);
  assign lim_acc = lim_w <<< sh;
  assign est_raw = acc >>> sh;
  assign est_w   = (est_raw > lim_w) ? lim_w : (est_raw < -lim_w) ? -lim_w : est_raw;
  assign est     = est_w[DW-1:0];

  assign diff = {in_data[DW-1], in_data} - {est[DW-1], est};
  assign y    = !enable ? in_data :
                (diff > SMAX) ? SMAX[DW-1:0] :
                (diff < SMIN) ? SMIN[DW-1:0] : diff[DW-1:0];

  assign acc_sum = acc + {{(ACCW-DW){y[DW-1]}}, y};
  assign acc_nxt = (acc_sum > lim_acc) ? lim_acc : (acc_sum < -lim_acc) ? -lim_acc : acc_sum;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc       <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_data <= y;
      if (!enable) acc <= '0;
      else if (in_valid && !freeze) acc <= acc_nxt;
    end
  end

  assert_valid_lat_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  assert_valid_gap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  assert_bypass_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable && in_valid) |=> (out_data == $past(in_data)));
  assert_acc_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (acc == '0));
  assert_freeze_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && freeze) |=> $stable(acc));
  assert_est_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (est_w <= lim_w) && (est_w >= -lim_w));

endmodule

// File: tb/tb_dc_trim_loop.sv
module tb_dc_trim_loop;
  localparam int TRIM = 20;
  localparam int LIM  = 128;

  logic clk = 0, rst_n = 0, enable = 0, freeze = 0, in_valid = 0;
  logic [2:0] tc_sel = 3'd0;
  logic signed [13:0] in_data = '0;
  logic out_valid;
  logic signed [13:0] out_data;

  int checks = 0, fails = 0;
  longint macc = 0;
  longint last_out = 0;

  always #10 clk = ~clk;

  dc_trim_loop #(.DW(14), .LIMIT(LIM), .TC_TRIM(TRIM)) dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .freeze(freeze), .tc_sel(tc_sel),
    .in_valid(in_valid), .in_data(in_data), .out_valid(out_valid), .out_data(out_data));

  function automatic int tshift(input logic [2:0] c);
    int t;
    case (c)
      3'd3: t = 24;  3'd2: t = 25;  3'd1: t = 26;
      3'd4: t = 28;  3'd5: t = 29;  default: t = 27;
    endcase
    return t - TRIM;
  endfunction

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive(input int x, input logic v, input string req);
    longint e, d, y, la;
    int k;
    k = tshift(tc_sel);
    la = longint'(LIM) <<< k;
    e = macc >>> k;
    if (e > LIM) e = LIM;
    if (e < -LIM) e = -LIM;
    d = x - e;
    if (d > 8191) d = 8191;
    if (d < -8192) d = -8192;
    y = enable ? d : x;
    if (!enable) macc = 0;
    else if (v && !freeze) begin
      macc = macc + y;
      if (macc > la) macc = la;
      if (macc < -la) macc = -la;
    end
    in_data = 14'(x);
    in_valid = v;
    @(negedge clk);
    chk("R1 valid", out_valid, v);
    if (v) begin
      chk(req, out_data, y);
      last_out = out_data;
    end
  endtask

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    longint sum;
    longint held;
    repeat (3) @(negedge clk);
    chk("R1 reset valid", out_valid, 0);
    chk("R1 reset data", out_data, 0);
    rst_n = 1;
    @(negedge clk);

    // R2: bypass sweep with valid gaps
    for (int x = -8192; x < 8192; x += 97) drive(x, (x % 5) != 0, "R2 bypass");
    drive(8191, 1, "R2 bypass max");
    drive(-8192, 1, "R2 bypass min");

    // R3/R4/R5: every code, offset plus tone, exact arithmetic
    for (int c = 0; c < 8; c++) begin
      enable = 0; tc_sel = 3'(c);
      drive(0, 1, "R2 clear");
      enable = 1;
      drive(400, 1, "R2 first sample after enable");
      chk("R2 restart from zero", last_out, 400);
      for (int i = 0; i < 300; i++)
        drive(90 + (((i % 8) < 4) ? 40 : -40), 1, "R5 decode/R4 loop");
    end

    // R8: convergence with shortest constant
    enable = 0; tc_sel = 3'd3;
    drive(0, 1, "R2 clear");
    enable = 1;
    sum = 0;
    for (int i = 0; i < 400; i++) begin
      drive(100 + (((i % 8) < 4) ? 40 : -40), 1, "R3 corrected");
      if (i >= 336) sum += last_out;
    end
    chk("R8 residual mean small", ((sum / 64) <= 3 && (sum / 64) >= -3), 1);

    // R6: freeze keeps output constant for constant input
    freeze = 1;
    drive(100, 1, "R6 frozen");
    held = last_out;
    for (int i = 0; i < 20; i++) begin
      drive(100, 1, "R6 frozen");
      chk("R6 constant out", last_out, held);
    end
    freeze = 0;

    // R7: code change mid-run, accumulator kept
    tc_sel = 3'd4;
    for (int i = 0; i < 50; i++) drive(100, 1, "R7 code change");
    tc_sel = 3'd3;
    for (int i = 0; i < 50; i++) drive(100, 1, "R7 code change back");

    // R3: saturation at both rails
    enable = 0; drive(0, 1, "R2 clear"); enable = 1;
    for (int i = 0; i < 300; i++) drive(120, 1, "R3 converge +");
    freeze = 1;
    drive(-8192, 1, "R3 low rail");
    chk("R3 low saturation", last_out, -8192);
    freeze = 0;
    enable = 0; drive(0, 1, "R2 clear"); enable = 1;
    for (int i = 0; i < 300; i++) drive(-120, 1, "R3 converge -");
    freeze = 1;
    drive(8191, 1, "R3 high rail");
    chk("R3 high saturation", last_out, 8191);
    freeze = 0;

    // R4: offset beyond limit leaves fixed residual
    enable = 0; drive(0, 1, "R2 clear"); enable = 1;
    for (int i = 0; i < 400; i++) drive(1000, 1, "R4 clamp");
    chk("R4 clamped residual", last_out, 1000 - LIM);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule